// File: doc/BRIEF.md
# Serial Seven-Segment Display Power-Up Sequencer

This block drives an external eight-digit seven-segment display controller over a write-only SPI link. After a single `start` pulse it runs a fixed list of register writes without further help. The writes set a mixed decode mask, scan every digit, wake the display from shutdown and load every digit register, so the panel shows a clock reading of `00-00-00`. The two separator positions, digits 2 and 5, carry a raw segment pattern that lights only the middle bar. The other six digits use the controller's built-in numeric decoding and show zero.

Each register write is a separate frame. Chip select drops, a 16-bit word goes out most significant bit first with the register address in the upper byte and the value in the lower byte, and chip select rises again. The serial clock runs at one sixteenth of the system clock in SPI mode 0. The block has no data stream of its own: `start`, `busy` and `done` are plain level and pulse signals with no handshake, and the block does not accept display updates or read anything back.

Top module: `spi7_init_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first start, cs_n is 1 and sclk, mosi, busy and done are all 0.
- R2: A start pulse taken while busy is 0 raises busy on the next clock edge. busy stays 1 until the last frame and its trailing chip-select gap are complete, and cs_n goes low only while busy is 1.
- R3: One sequence emits exactly 11 frames. Each frame has exactly 16 sclk rising edges while cs_n is low, address byte first then data byte, each byte MSB first.
- R4: The 16-bit frame words ({address, data}) are, in order: 0x09DB (decode mask, digits 0,1,3,4,6,7 decoded), 0x0B07 (scan all eight digits), 0x0C01 (leave shutdown), then 0x0100, 0x0200, 0x0301, 0x0400, 0x0500, 0x0601, 0x0700, 0x0800 (digit registers 1 to 8, where the value 0x01 on digits 2 and 5 lights the middle segment only).
- R5: sclk idles low and is low whenever cs_n is high. Within a frame each sclk period is 16 system clocks, 8 low followed by 8 high, and the first rising edge comes 8 clocks after cs_n falls.
- R6: mosi changes only on the clock edge where sclk falls or cs_n falls, so it is stable across every rising sclk edge.
- R7: Between two frames of one sequence cs_n stays high for at least 16 system clocks.
- R8: done is a single-cycle pulse, issued once per sequence after the last frame, in the same cycle that busy returns to 0.
- R9: start pulses that arrive while busy is 1 are ignored: the running sequence keeps its 11 frames in order and no extra sequence follows.
- R10: After done, a new start replays the identical 11-frame sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins the sequence when the block is idle |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle pulse when the sequence completes |
| sclk | output | 1 | Serial clock, mode 0, system clock / 16 |
| mosi | output | 1 | Serial data to the display controller |
| cs_n | output | 1 | Chip select, active low, one low period per frame |

## Verification
On every cycle the assertions check the serial line discipline: sclk is held low while deselected, mosi moves only when sclk or chip select falls, frames are launched only into an idle shifter, chip select is low only while busy, and done is a lone pulse with busy already low. Whether the frame words are correct and in the right order, whether the clock high time, period and inter-frame gap have the right lengths, and whether start pulses during a run are ignored can only be shown by the bench's scenarios. The bench decodes each frame at the rising sclk edges and compares it with its own table.

// File: rtl/spi7_pkg.sv
package spi7_pkg;

  localparam int unsigned WORD_BITS = 16;

  localparam logic [7:0] REG_DECODE   = 8'h09;
  localparam logic [7:0] REG_SCAN     = 8'h0B;
  localparam logic [7:0] REG_SHUTDOWN = 8'h0C;
  localparam logic [7:0] SEG_MIDDLE   = 8'h01;

  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;

  // Digit positions 2, 5 (every third one) are separators: raw segments.
  function automatic logic is_separator(int unsigned digit);
    return (digit % 3) == 2;
  endfunction

  // Command word for list position idx: {register address, value}.
  function automatic logic [WORD_BITS-1:0] cmd_word(int unsigned idx, int unsigned ndig);
    logic [7:0] mask;
    int unsigned d;
    mask = '0;
    for (int k = 0; k < 8; k++) begin
      if (k < ndig && !is_separator(k)) mask[k] = 1'b1;
    end
    if (idx == 0) return {REG_DECODE, mask};
    if (idx == 1) return {REG_SCAN, 8'(ndig - 1)};
    if (idx == 2) return {REG_SHUTDOWN, 8'h01};
    d = idx - 3;
    return {8'(d + 1), is_separator(d) ? SEG_MIDDLE : 8'h00};
  endfunction

endpackage

// File: rtl/spi7_cmd_rom.sv
module spi7_cmd_rom #(
  parameter int unsigned NUM_DIGITS = 8,
  localparam int unsigned NUM_CMDS = 3 + NUM_DIGITS,
  localparam int unsigned IW = $clog2(NUM_CMDS)
) (
  input  logic [IW-1:0]                   idx,
  output logic [spi7_pkg::WORD_BITS-1:0]  word
);
  always_comb word = spi7_pkg::cmd_word(32'(idx), NUM_DIGITS);
endmodule

// File: rtl/spi7_frame_tx.sv
module spi7_frame_tx #(
  parameter int unsigned CLK_DIV = 16,
  parameter int unsigned BITS    = 16,
  parameter int unsigned GAP     = 16,
  localparam int unsigned HALF = CLK_DIV / 2,
  localparam int unsigned DW   = $clog2(CLK_DIV),
  localparam int unsigned BW   = $clog2(BITS),
  localparam int unsigned GW   = $clog2(GAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [BITS-1:0] word,
  output logic            idle,
  output logic            fin,
  output logic            sclk,
  output logic            mosi,
  output logic            cs_n
);
  import spi7_pkg::*;

  tx_state_e       st;
  logic [DW-1:0]   div;
  logic [BW-1:0]   bitn;
  logic [GW-1:0]   gap;
  logic [BITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      div  <= '0;
      bitn <= '0;
      gap  <= '0;
      sh   <= '0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        TX_IDLE: if (go) begin
          sh   <= word;
          cs_n <= 1'b0;
          div  <= '0;
          bitn <= '0;
          st   <= TX_SHIFT;
        end
        TX_SHIFT: begin
          div <= div + 1'b1;
          if (div == DW'(HALF - 1)) sclk <= 1'b1;
          if (div == DW'(CLK_DIV - 1)) begin
            sclk <= 1'b0;
            div  <= '0;
            if (bitn == BW'(BITS - 1)) begin
              cs_n <= 1'b1;
              sh   <= '0;
              gap  <= '0;
              st   <= TX_GAP;
            end else begin
              sh   <= {sh[BITS-2:0], 1'b0};
              bitn <= bitn + 1'b1;
            end
          end
        end
        TX_GAP: begin
          gap <= gap + 1'b1;
          if (gap == GW'(GAP - 1)) begin
            fin <= 1'b1;
            st  <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign idle = (st == TX_IDLE);
  assign mosi = sh[BITS-1];

  p_sclk_low_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_mosi_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($fell(sclk) || $fell(cs_n)));

  p_mosi_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi7_init_seq.sv
module spi7_init_seq #(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned CLK_DIV    = 16,
  parameter int unsigned GAP_CYCLES = 16,
  localparam int unsigned NUM_CMDS  = 3 + NUM_DIGITS,
  localparam int unsigned IW        = $clog2(NUM_CMDS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic sclk,
  output logic mosi,
  output logic cs_n
);
  import spi7_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(NUM_CMDS - 1);

  logic                 run;
  logic                 go;
  logic [IW-1:0]        idx;
  logic [WORD_BITS-1:0] word;
  logic                 tx_idle;
  logic                 tx_fin;

  spi7_cmd_rom #(.NUM_DIGITS(NUM_DIGITS)) u_rom (
    .idx  (idx),
    .word (word)
  );

  spi7_frame_tx #(.CLK_DIV(CLK_DIV), .BITS(WORD_BITS), .GAP(GAP_CYCLES)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .word  (word),
    .idle  (tx_idle),
    .fin   (tx_fin),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      go   <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run <= 1'b1;
          idx <= '0;
          go  <= 1'b1;
        end
      end else if (tx_fin) begin
        if (idx == LAST) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          go  <= 1'b1;
        end
      end
    end
  end

  assign busy = run;

  p_start_accepted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_frames_inside_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  p_launch_into_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> tx_idle);

  p_done_with_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/spi7_init_seq_test.sv
module spi7_init_seq_test;
  localparam int CLK_DIV = 16;
  localparam int GAP     = 16;
  localparam int NFRAMES = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, sclk, mosi, cs_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit timed_out = 0;

  spi7_init_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] exp_word(int i);
    case (i)
      0: return 16'h09DB;
      1: return 16'h0B07;
      2: return 16'h0C01;
      3: return 16'h0100;
      4: return 16'h0200;
      5: return 16'h0301;
      6: return 16'h0400;
      7: return 16'h0500;
      8: return 16'h0601;
      9: return 16'h0700;
      default: return 16'h0800;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Line monitor, sampled on the falling system clock edge.
  logic prev_sclk = 0, prev_cs = 1, prev_mosi = 0;
  logic [15:0] fsh = 0;
  int fbits = 0, fidx = 0, since_rise = 0, hi_cnt = 0, gap_cnt = 0;
  int bad_period = 0, bad_mosi = 0, bad_gap = 0, done_cnt = 0, bad_done_busy = 0;
  int bad_first = 0, lead = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && !prev_sclk) begin
        if (!cs_n) begin
          if (fbits > 0 && since_rise != CLK_DIV) bad_period++;
          if (fbits == 0 && lead != CLK_DIV / 2) bad_first++;
          fsh = {fsh[14:0], mosi};
          fbits++;
        end
        since_rise = 1;
      end else since_rise++;
      if (sclk) hi_cnt++;
      if (!sclk && prev_sclk) begin
        if (hi_cnt != CLK_DIV / 2) bad_period++;
        hi_cnt = 0;
      end
      if (cs_n && sclk) bad_period++;
      if (mosi != prev_mosi && !(prev_sclk && !sclk) && !(prev_cs && !cs_n)) bad_mosi++;
      if (!cs_n) lead++;
      if (!cs_n && prev_cs) begin
        if (fidx > 0 && gap_cnt < GAP) bad_gap++;
        fbits = 0;
        lead = 1;
      end
      if (cs_n && !prev_cs) begin
        chk(fbits == 16, "R3", "bits in frame", fbits, 16);
        if (fidx < NFRAMES)
          chk(fsh == exp_word(fidx), "R4", $sformatf("frame %0d word", fidx), fsh, exp_word(fidx));
        else
          chk(0, "R3", "extra frame", fidx, NFRAMES - 1);
        fidx++;
        gap_cnt = 0;
      end
      if (cs_n) gap_cnt++;
      if (done) begin
        done_cnt++;
        if (busy) bad_done_busy++;
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
      prev_mosi = mosi;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !timed_out) begin
      timed_out = 1;
      chk(0, "watchdog", "run did not finish", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_seq(int spam, string rq);
    int not_busy = 0;
    fidx = 0; done_cnt = 0; bad_period = 0; bad_mosi = 0; bad_gap = 0;
    bad_done_busy = 0; bad_first = 0;
    repeat (1 + $urandom % 20) @(posedge clk);
    #1 start = 1;
    @(posedge clk);
    #1 start = 0;
    chk(busy == 1, "R2", "busy after start", busy, 1);
    while (!done && !timed_out) begin
      @(posedge clk);
      #1;
      if (!done && !busy) not_busy++;
      start = (!done && spam != 0 && ($urandom % 64) == 0);
    end
    start = 0;
    chk(busy == 0, "R8", "busy low with done", busy, 0);
    repeat (CLK_DIV * 4) @(posedge clk);
    #1;
    chk(not_busy == 0, "R2", "busy dropped early", not_busy, 0);
    chk(fidx == NFRAMES, rq, "frames in sequence", fidx, NFRAMES);
    chk(done_cnt == 1, "R8", "done cycles", done_cnt, 1);
    chk(bad_done_busy == 0, "R8", "done with busy", bad_done_busy, 0);
    chk(bad_period == 0, "R5", "sclk timing faults", bad_period, 0);
    chk(bad_first == 0, "R5", "first rise lead faults", bad_first, 0);
    chk(bad_mosi == 0, "R6", "mosi off-edge changes", bad_mosi, 0);
    chk(bad_gap == 0, "R7", "short cs gaps", bad_gap, 0);
    chk(busy == 0 && cs_n == 1, "R9", "idle after sequence", {busy, cs_n}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0, "R1",
        "outputs in reset", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    rst_n = 1;
    repeat (5) @(posedge clk);
    #1;
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0, "R1",
        "outputs idle after reset", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    run_seq(0, "R3");
    run_seq(1, "R9");
    for (int i = 0; i < 3; i++) run_seq($urandom % 2, "R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule